// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block turns a free-running reference clock into a divided clock-enable level, `out_en`. The high phase and the low phase each have their own length, so software sets period and duty cycle separately. A downstream clock gate treats `out_en` as a qualifier: every reference edge seen while it is 1 is forwarded. When the divider is switched off, `out_en` stays at 1 and the reference passes undivided. When the channel's gate is closed, `out_en` stays at 0.

Software writes three registers through a single-cycle write port:
- a control word holding a divider-enable bit and a gate-enable bit;
- a high-length field;
- a low-length field.

Each length field holds its phase length minus one. For an even divide ratio N, both fields are written with N/2 − 1, which gives a 50% duty cycle.

New settings are first held in shadow registers. They are copied into the running configuration only when a low phase has finished, so a phase is never cut short.

The controller is a four-state machine:
- **ST_STOP**: output 0, gate closed.
- **ST_PASS**: output 1, bypass.
- **ST_HIGH**: high phase, counting down.
- **ST_LOW**: low phase, counting down.

Transitions:
- **load**: from ST_STOP, ST_PASS, or the last cycle of ST_LOW. The shadow settings are sampled, and the next state is ST_STOP if the gate is closed, ST_PASS if the divider is off, otherwise ST_HIGH.
- **fall**: from the last cycle of ST_HIGH to ST_LOW.
- **hold**: counting down inside ST_HIGH or ST_LOW.

A build parameter, `HAS_GATE`, removes the gate register for an always-on channel.

Top module: `clkdiv_hilo`

## Requirements
- R1: With the gate bit set and the divider-enable bit clear, `out_en` is held at 1 on every reference cycle.
- R2: With the divider enabled, each high phase of `out_en` lasts (high field + 1) reference cycles.
- R3: With the divider enabled, each low phase of `out_en` lasts (low field + 1) reference cycles.
- R4: The divided period is (high field + 1) + (low field + 1) cycles; both fields at zero gives the minimum ratio of 2.
- R5: For an even ratio N, writing N/2 − 1 to both fields yields equal high and low runs of N/2 cycles.
- R6: Clearing the gate bit lets the running high and low phases finish, then holds `out_en` at 0.
- R7: A channel built with `HAS_GATE = 0` runs as if its gate were always set; writes to the gate bit do not stop it.
- R8: A field written during a high phase does not change that phase's length; new values apply from the next load.
- R9: Register map:
  - address 0 is control: bit 0 is divider enable, bit 1 is gate enable;
  - address 1 is the high field, in the low `CNT_W` bits;
  - address 2 is the low field, in the low `CNT_W` bits;
  - a write to address 3 has no effect.
- R10: Synchronous active-high reset clears the enable and gate bits, so a gated channel holds `out_en` at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| out_en | output | 1 | Divided clock-enable level |

## Verification
The in-RTL assertions check the following on every cycle:
- the countdown within each phase;
- that the low-phase length loaded at the high-to-low edge matches the one latched at load;
- that a high phase can only be followed by more high or by low, so it is never truncated;
- the bypass level;
- the gate-off stop at the end of a low phase;
- that an always-on channel never returns to the stopped state.

Only the bench's scenarios can show the end-to-end behaviour:
- measured high and low run lengths against the programmed fields over random settings;
- 50% duty for even ratios;
- the ignored address;
- the deferred effect of a write made mid-phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_PASS = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } phase_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HIGH = 2'd1;
    localparam logic [1:0] ADDR_LOW  = 2'd2;

    localparam int CTRL_DIV_BIT  = 0;
    localparam int CTRL_GATE_BIT = 1;

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 2,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              div_en,
    output logic              gate_en,
    output logic [CNT_W-1:0]  hi_field,
    output logic [CNT_W-1:0]  lo_field
);

    logic wr_ctrl;
    logic wr_high;
    logic wr_low;

    // R9: decode of the register map; address 3 selects nothing
    assign wr_ctrl = wr_valid && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_high = wr_valid && (wr_addr == ADDR_W'(ADDR_HIGH));
    assign wr_low  = wr_valid && (wr_addr == ADDR_W'(ADDR_LOW));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_en   <= 1'b0;
            hi_field <= '0;
            lo_field <= '0;
        end else begin
            if (wr_ctrl) div_en   <= wr_data[CTRL_DIV_BIT];
            if (wr_high) hi_field <= wr_data[CNT_W-1:0];
            if (wr_low)  lo_field <= wr_data[CNT_W-1:0];
        end
    end

    generate
        if (HAS_GATE) begin : g_gate
            logic gate_q;
            always_ff @(posedge clk) begin
                if (rst)          gate_q <= 1'b0;
                else if (wr_ctrl) gate_q <= wr_data[CTRL_GATE_BIT];
            end
            assign gate_en = gate_q;
        end else begin : g_always_on
            // R7: no gate storage; gate bit writes are dropped
            assign gate_en = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] value,
    output logic             zero
);

    always_ff @(posedge clk) begin
        if (rst)                value <= '0;
        else if (load)          value <= load_val;
        else if (dec && !zero)  value <= value - 1'b1;
    end

    assign zero = (value == '0);

endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_en,
    input  logic             gate_en,
    input  logic [CNT_W-1:0] hi_field,
    input  logic [CNT_W-1:0] lo_field,
    output phase_e           state_q,
    output logic             cnt_zero,
    output logic             out_en
);

    phase_e           state_d;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] lo_act_q;
    logic             take_cfg;

    clkdiv_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .value    (cnt_val),
        .zero     (cnt_zero)
    );

    function automatic phase_e pick_state(input logic gate, input logic div);
        if (!gate)     return ST_STOP;
        else if (!div) return ST_PASS;
        else           return ST_HIGH;
    endfunction

    // next-state and counter control
    always_comb begin
        state_d      = state_q;
        cnt_load     = 1'b0;
        cnt_load_val = hi_field;
        cnt_dec      = 1'b0;
        take_cfg     = 1'b0;
        unique case (state_q)
            ST_STOP, ST_PASS: begin
                state_d  = pick_state(gate_en, div_en);
                take_cfg = 1'b1;
            end
            ST_HIGH: begin
                if (cnt_zero) begin
                    state_d      = ST_LOW;
                    cnt_load     = 1'b1;
                    cnt_load_val = lo_act_q;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt_zero) begin
                    state_d  = pick_state(gate_en, div_en);
                    take_cfg = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: state_d = ST_STOP;
        endcase
        if (take_cfg && state_d == ST_HIGH) begin
            cnt_load     = 1'b1;
            cnt_load_val = hi_field;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_STOP;
            lo_act_q <= '0;
        end else begin
            state_q <= state_d;
            if (take_cfg && state_d == ST_HIGH) lo_act_q <= lo_field;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_PASS, ST_HIGH: out_en = 1'b1;
            default:          out_en = 1'b0;
        endcase
    end

    p_high_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH && !cnt_zero) |=> (state_q == ST_HIGH));

    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_HIGH || state_q == ST_LOW) && !cnt_zero)
        |=> (cnt_val == $past(cnt_val) - 1'b1));

    p_low_load_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH && cnt_zero)
        |=> (state_q == ST_LOW && cnt_val == $past(lo_act_q)));

    p_low_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW && !cnt_zero) |=> (state_q == ST_LOW));

    p_no_runt_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH) |=> (state_q == ST_HIGH || state_q == ST_LOW));

endmodule

// File: rtl/clkdiv_hilo.sv
module clkdiv_hilo
    import clkdiv_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 2,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_en
);

    logic             div_en;
    logic             gate_en;
    logic [CNT_W-1:0] hi_field;
    logic [CNT_W-1:0] lo_field;
    phase_e           state;
    logic             cnt_zero;

    clkdiv_regs #(
        .CNT_W    (CNT_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .HAS_GATE (HAS_GATE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .div_en   (div_en),
        .gate_en  (gate_en),
        .hi_field (hi_field),
        .lo_field (lo_field)
    );

    clkdiv_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .div_en   (div_en),
        .gate_en  (gate_en),
        .hi_field (hi_field),
        .lo_field (lo_field),
        .state_q  (state),
        .cnt_zero (cnt_zero),
        .out_en   (out_en)
    );

    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !div_en && (state == ST_PASS || state == ST_STOP))
        |=> out_en);

    p_gate_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (!gate_en && state == ST_LOW && cnt_zero) |=> !out_en);

    generate
        if (!HAS_GATE) begin : g_chk_on
            p_always_on_r7: assert property (@(posedge clk) disable iff (rst)
                (!rst) |=> (state != ST_STOP));
        end
    endgenerate

endmodule

// File: tb/sim_clkdiv_hilo.sv
`timescale 1ns/1ps
module sim_clkdiv_hilo;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              out_en;
    logic              out_on;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_hilo #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_GATE(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_en(out_en)
    );

    clkdiv_hilo #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_GATE(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_en(out_on)
    );

    // run-length monitor on u0
    logic prev_out = 1'b0;
    int run_len = 0;
    int last_hi = 0;
    int last_lo = 0;
    int hi_done = 0;
    int lo_done = 0;
    int on_edges = 0;
    logic prev_on = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            run_len  <= 0;
            prev_out <= 1'b0;
            prev_on  <= 1'b0;
        end else begin
            if (out_on != prev_on) on_edges <= on_edges + 1;
            prev_on <= out_on;
            if (out_en == prev_out) begin
                run_len <= run_len + 1;
            end else begin
                if (prev_out) begin
                    last_hi <= run_len;
                    hi_done <= hi_done + 1;
                end else begin
                    last_lo <= run_len;
                    lo_done <= lo_done + 1;
                end
                run_len <= 1;
            end
            prev_out <= out_en;
        end
    end

    function automatic int exp_len(input int field);
        return field + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = DATA_W'(d);
        step();
        wr_valid = 1'b0;
    endtask

    task automatic wait_hi(input int n);
        int target = hi_done + n;
        while (hi_done < target) step();
    endtask

    task automatic wait_lo(input int n);
        int target = lo_done + n;
        while (lo_done < target) step();
    endtask

    task automatic program_and_measure(input int h, input int l, output int mh, output int ml);
        wr(2'd1, h);
        wr(2'd2, l);
        wr(2'd0, 3);
        wait_hi(3);
        mh = last_hi;
        wait_lo(1);
        ml = last_lo;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int mh, ml, h, l, n, ones;
        void'($urandom(32'd1234));
        repeat (4) step();
        rst = 1'b0;
        repeat (3) step();

        // R10: gated channel idle after reset
        check(out_en == 1'b0, "R10 reset out", out_en, 0);
        // R7: ungated channel bypasses right after reset
        check(out_on == 1'b1, "R7 always-on after reset", out_on, 1);

        // R1: bypass, gate only
        wr(2'd0, 2);
        repeat (2) step();
        ones = 0;
        for (int i = 0; i < 16; i++) begin
            if (out_en) ones++;
            step();
        end
        check(ones == 16, "R1 bypass level", ones, 16);

        // R4: minimum ratio 2
        program_and_measure(0, 0, mh, ml);
        check(mh + ml == 2, "R4 min ratio", mh + ml, 2);
        check(mh == 1, "R2 high len zero field", mh, 1);

        // R2/R3 directed asymmetric
        program_and_measure(3, 6, mh, ml);
        check(mh == exp_len(3), "R2 high len", mh, exp_len(3));
        check(ml == exp_len(6), "R3 low len", ml, exp_len(6));

        // random settings
        for (int t = 0; t < 12; t++) begin
            h = $urandom % 48;
            l = $urandom % 48;
            program_and_measure(h, l, mh, ml);
            check(mh == exp_len(h), "R2 random high", mh, exp_len(h));
            check(ml == exp_len(l), "R3 random low", ml, exp_len(l));
            check(mh + ml == exp_len(h) + exp_len(l), "R4 period", mh + ml, exp_len(h) + exp_len(l));
        end

        // R5: even ratios, 50% duty
        for (int t = 0; t < 4; t++) begin
            n = 2 * (1 + ($urandom % 30));
            program_and_measure(n / 2 - 1, n / 2 - 1, mh, ml);
            check(mh == ml, "R5 duty equal", mh, ml);
            check(mh + ml == n, "R5 ratio", mh + ml, n);
        end

        // R9: address 3 ignored
        program_and_measure(4, 4, mh, ml);
        wr(2'd3, 16'hFFFF);
        wait_hi(3);
        check(last_hi == 5, "R9 addr3 high", last_hi, 5);
        wait_lo(1);
        check(last_lo == 5, "R9 addr3 low", last_lo, 5);

        // R8: write mid-high does not shorten current high
        program_and_measure(9, 9, mh, ml);
        while (!(out_en && run_len == 1)) step();
        wr(2'd1, 2);
        wait_hi(1);
        check(last_hi == 10, "R8 high kept", last_hi, 10);
        wait_hi(2);
        check(last_hi == 3, "R8 new high applied", last_hi, 3);

        // R6: gate off mid-high, phases finish then stop
        program_and_measure(9, 9, mh, ml);
        while (!(out_en && run_len == 1)) step();
        n = on_edges;
        wr(2'd0, 1);
        wait_hi(1);
        check(last_hi == 10, "R6 high not truncated", last_hi, 10);
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            if (out_en) ones++;
            step();
        end
        check(ones == 0, "R6 stopped", ones, 0);
        // R7: ungated channel kept running through the gate clear
        check(on_edges > n, "R7 ungated runs", on_edges - n, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule